// File: doc/BRIEF.md
# Instruction Reorder Buffer

This block keeps in-flight instructions of a speculative out-of-order core in a circular buffer, in program order. Decode places each new instruction at the tail and receives its slot index, which serves as the instruction's tag. An operand is either a value read from the register file or the tag of an older instruction still in the buffer. An entry whose two operands are both valid can go to an execution unit. That unit later returns a result under the entry's tag, and the result is forwarded to every operand still waiting on that tag.

Retirement happens strictly from the head. A finished entry is presented on the commit port for one cycle, so that the register file (or the store path) can consume it, and its slot is freed. A mispredicted branch marks every entry younger than itself as killed. Killed entries are never dispatched, ignore writebacks and are freed at the head without any commit.

Each entry moves through five states: empty, waiting, dispatched, done and killed. The head and tail pointers each carry an extra wrap bit, so the block can tell a full buffer from an empty one.

Top module: `rob_core`

## Requirements
- R1: After reset every slot is empty, `ins_ready` is 1, `ins_tag` is 0, and `dsp_valid` and `cmt_valid` are 0.
- R2: When `ins_valid` is high and `ins_ready` is high, the instruction is written into the slot given by `ins_tag`. That slot becomes waiting, and `ins_tag` then advances by one modulo DEPTH.
- R3: `ins_ready` is 0 while all DEPTH slots are occupied. An insert offered in that state changes nothing: no slot is written and `ins_tag` does not move.
- R4: When `dsp_req` is high in a cycle without `br_valid`, the oldest waiting entry whose two operands are both valid is marked dispatched. In the next cycle it appears on `dsp_valid`, `dsp_tag`, `dsp_instr`, `dsp_a` and `dsp_b`. With no eligible entry, `dsp_valid` is 0 in the next cycle.
- R5: A writeback (`wb_valid`, `wb_tag`, `wb_data`) to a dispatched entry stores `wb_data` as that entry's result and marks it done. The same value is loaded into every operand that is not yet valid and names `wb_tag`, and that operand becomes valid.
- R6: If an insert names, as a not-ready operand, the tag that is written back in the same cycle, the operand is stored valid with `wb_data`, not as a pending tag.
- R7: When the head entry is done, the next cycle shows `cmt_valid` with its tag, instruction and result. The slot is freed and the head advances. At most one entry retires per cycle, and entries retire in insertion order.
- R8: When `br_valid` is high, every occupied entry younger than the entry `br_tag` becomes killed, including an instruction inserted in that same cycle. A killed entry is never dispatched.
- R9: A killed entry at the head is freed without `cmt_valid`, and a writeback addressed to a killed entry is ignored.
- R10: Tags wrap modulo DEPTH. A buffer holding DEPTH entries reads as full and an empty one as empty, even though both have equal slot indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Decode offers an instruction |
| ins_instr | input | IW | Instruction word |
| ins_a_rdy | input | 1 | Operand A holds a value (else a tag) |
| ins_a_data | input | DW | Operand A value |
| ins_a_tag | input | log2(DEPTH) | Operand A producer tag |
| ins_b_rdy | input | 1 | Operand B holds a value (else a tag) |
| ins_b_data | input | DW | Operand B value |
| ins_b_tag | input | log2(DEPTH) | Operand B producer tag |
| ins_ready | output | 1 | A free slot exists |
| ins_tag | output | log2(DEPTH) | Slot (tag) the next insert takes |
| dsp_req | input | 1 | An execution unit asks for work |
| dsp_valid | output | 1 | Dispatched entry is presented |
| dsp_tag | output | log2(DEPTH) | Tag of dispatched entry |
| dsp_instr | output | IW | Instruction of dispatched entry |
| dsp_a | output | DW | Operand A value |
| dsp_b | output | DW | Operand B value |
| wb_valid | input | 1 | Result returned |
| wb_tag | input | log2(DEPTH) | Tag of producing entry |
| wb_data | input | DW | Result value |
| br_valid | input | 1 | Mispredicted branch resolved |
| br_tag | input | log2(DEPTH) | Tag of the branch entry |
| cmt_valid | output | 1 | An entry retires |
| cmt_tag | output | log2(DEPTH) | Tag of retiring entry |
| cmt_instr | output | IW | Instruction of retiring entry |
| cmt_data | output | DW | Result to write to the register file |

## Verification
Two pairs of functions can meet in one cycle. The first pair is an insert and the writeback of the result that the new instruction needs. The bench offers an insert whose operand names tag 0 in the very cycle that tag 0 is written back. It then dispatches that instruction and expects the written-back value on `dsp_a`, where a lost forward would leave the instruction waiting for good. The second pair is a branch kill and an insert: the bench inserts an instruction in the kill cycle, and then expects it never to be dispatched and to leave the head without `cmt_valid`. A later writeback to an already killed entry is checked the same way, by the absence of any commit for that tag.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [2:0] {
    ST_EMPTY = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DISP  = 3'd2,
    ST_KILL  = 3'd3,
    ST_DONE  = 3'd4
  } rob_state_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointers with wrap bit; DEPTH must be a power of two.
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_head,
  input  logic          inc_tail,
  output logic [AW-1:0] head_idx,
  output logic [AW-1:0] tail_idx,
  output logic          full
);
  logic [AW:0] head_q, tail_q;
  logic        empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (inc_head) head_q <= head_q + (AW+1)'(1);
      if (inc_tail) tail_q <= tail_q + (AW+1)'(1);
    end
  end

  assign head_idx = head_q[AW-1:0];
  assign tail_idx = tail_q[AW-1:0];
  assign empty    = (head_q == tail_q);
  assign full     = (head_q[AW] != tail_q[AW]) && (head_idx == tail_idx);

  // R3: tail never advances into an occupied slot
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    inc_tail |-> !full);
  // R7 / R10: head never advances past the tail
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    inc_head |-> !empty);
endmodule

// File: rtl/rob_pick.sv
// Picks the oldest eligible slot, scanning from the head.
module rob_pick #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]    head_idx,
  input  logic [DEPTH-1:0] ready_vec,
  output logic             found,
  output logic [AW-1:0]    sel
);
  logic [AW-1:0] idx;

  always_comb begin
    found = 1'b0;
    sel   = head_idx;
    idx   = head_idx;
    // scan youngest to oldest so the oldest match is written last
    for (int k = DEPTH-1; k >= 0; k--) begin
      idx = head_idx + AW'(k);
      if (ready_vec[idx]) begin
        found = 1'b1;
        sel   = idx;
      end
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int IW    = 16,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins_valid,
  input  logic [IW-1:0] ins_instr,
  input  logic          ins_a_rdy,
  input  logic [DW-1:0] ins_a_data,
  input  logic [TW-1:0] ins_a_tag,
  input  logic          ins_b_rdy,
  input  logic [DW-1:0] ins_b_data,
  input  logic [TW-1:0] ins_b_tag,
  output logic          ins_ready,
  output logic [TW-1:0] ins_tag,
  input  logic          dsp_req,
  output logic          dsp_valid,
  output logic [TW-1:0] dsp_tag,
  output logic [IW-1:0] dsp_instr,
  output logic [DW-1:0] dsp_a,
  output logic [DW-1:0] dsp_b,
  input  logic          wb_valid,
  input  logic [TW-1:0] wb_tag,
  input  logic [DW-1:0] wb_data,
  input  logic          br_valid,
  input  logic [TW-1:0] br_tag,
  output logic          cmt_valid,
  output logic [TW-1:0] cmt_tag,
  output logic [IW-1:0] cmt_instr,
  output logic [DW-1:0] cmt_data
);
  rob_state_e    st_q   [DEPTH];
  logic [IW-1:0] instr_q[DEPTH];
  logic [DW-1:0] res_q  [DEPTH];
  logic          a_v    [DEPTH];
  logic          b_v    [DEPTH];
  logic [DW-1:0] a_d    [DEPTH];
  logic [DW-1:0] b_d    [DEPTH];
  logic [TW-1:0] a_t    [DEPTH];
  logic [TW-1:0] b_t    [DEPTH];

  logic [TW-1:0]    head_idx, tail_idx, pick_sel;
  logic             full, pick_found;
  logic [DEPTH-1:0] ready_vec, kill_vec;
  logic             ins_fire, wb_hit, dsp_fire, cmt_fire, free_fire;
  rob_state_e       head_st;

  function automatic logic [TW-1:0] age_of(input logic [TW-1:0] idx,
                                           input logic [TW-1:0] hd);
    return idx - hd;
  endfunction

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .inc_head(free_fire), .inc_tail(ins_fire),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full)
  );

  rob_pick #(.DEPTH(DEPTH)) u_pick (
    .head_idx(head_idx), .ready_vec(ready_vec),
    .found(pick_found), .sel(pick_sel)
  );

  assign ins_ready = !full;
  assign ins_tag   = tail_idx;
  assign ins_fire  = ins_valid && !full;
  assign wb_hit    = wb_valid && (st_q[wb_tag] == ST_DISP);
  assign dsp_fire  = dsp_req && pick_found && !br_valid;
  assign head_st   = st_q[head_idx];
  assign cmt_fire  = (head_st == ST_DONE);
  assign free_fire = (head_st == ST_DONE) || (head_st == ST_KILL);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ready_vec[i] = (st_q[i] == ST_WAIT) && a_v[i] && b_v[i];
      kill_vec[i]  = br_valid && (st_q[i] != ST_EMPTY) &&
                     (age_of(TW'(i), head_idx) > age_of(br_tag, head_idx));
    end
  end

  // entry storage and lifecycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i] <= ST_EMPTY;
        a_v[i]  <= 1'b0;
        b_v[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_fire && tail_idx == TW'(i)) begin
          st_q[i]    <= br_valid ? ST_KILL : ST_WAIT;
          instr_q[i] <= ins_instr;
          a_t[i]     <= ins_a_tag;
          b_t[i]     <= ins_b_tag;
          // same-cycle forward from writeback (R6)
          a_v[i] <= ins_a_rdy || (wb_hit && wb_tag == ins_a_tag);
          a_d[i] <= ins_a_rdy ? ins_a_data : wb_data;
          b_v[i] <= ins_b_rdy || (wb_hit && wb_tag == ins_b_tag);
          b_d[i] <= ins_b_rdy ? ins_b_data : wb_data;
        end else begin
          if (dsp_fire && pick_sel == TW'(i)) st_q[i] <= ST_DISP;
          if (wb_hit && wb_tag == TW'(i)) begin
            st_q[i]  <= ST_DONE;
            res_q[i] <= wb_data;
          end
          if (wb_hit && !a_v[i] && a_t[i] == wb_tag) begin
            a_v[i] <= 1'b1;
            a_d[i] <= wb_data;
          end
          if (wb_hit && !b_v[i] && b_t[i] == wb_tag) begin
            b_v[i] <= 1'b1;
            b_d[i] <= wb_data;
          end
          if (kill_vec[i]) st_q[i] <= ST_KILL;
          if (free_fire && head_idx == TW'(i)) st_q[i] <= ST_EMPTY;
        end
      end
    end
  end

  // registered dispatch and commit ports
  always_ff @(posedge clk) begin
    if (rst) begin
      dsp_valid <= 1'b0;
      cmt_valid <= 1'b0;
    end else begin
      dsp_valid <= dsp_fire;
      cmt_valid <= cmt_fire;
    end
    if (dsp_fire) begin
      dsp_tag   <= pick_sel;
      dsp_instr <= instr_q[pick_sel];
      dsp_a     <= a_d[pick_sel];
      dsp_b     <= b_d[pick_sel];
    end
    if (cmt_fire) begin
      cmt_tag   <= head_idx;
      cmt_instr <= instr_q[head_idx];
      cmt_data  <= res_q[head_idx];
    end
  end

  // R4: only an eligible entry is chosen, and it becomes dispatched
  assert_dispatch_eligible_R4: assert property (@(posedge clk) disable iff (rst)
    dsp_fire |-> (st_q[pick_sel] == ST_WAIT) && a_v[pick_sel] && b_v[pick_sel]);
  assert_dispatch_marked_R4: assert property (@(posedge clk) disable iff (rst)
    dsp_fire |=> dsp_valid && st_q[$past(pick_sel)] == ST_DISP);
  // R5: accepted writeback completes the producer
  assert_writeback_done_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_hit && !br_valid) |=> st_q[$past(wb_tag)] == ST_DONE);
  // R7: a done head retires on the next cycle
  assert_commit_head_R7: assert property (@(posedge clk) disable iff (rst)
    (head_st == ST_DONE) |=> cmt_valid && cmt_tag == $past(head_idx));
  // R9: killed head frees silently, killed entry ignores writeback
  assert_kill_no_commit_R9: assert property (@(posedge clk) disable iff (rst)
    (head_st == ST_KILL) |=> !cmt_valid);
  assert_kill_ignores_wb_R9: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && st_q[wb_tag] == ST_KILL) |=> st_q[$past(wb_tag)] != ST_DONE);
endmodule

// File: tb/rob_core_bench.sv
`timescale 1ns/1ps
module rob_core_bench;
  localparam int D  = 8;
  localparam int DW = 16;
  localparam int IW = 16;
  localparam int TW = $clog2(D);
  localparam int NV = 10;

  // stimulus table: operand A, operand B, operation (0 add,1 sub,2 xor,3 and)
  localparam logic [15:0] VA [NV] = '{16'h0001, 16'h1234, 16'hFFFF, 16'h00F0, 16'h8000,
                                      16'h0F0F, 16'h7FFF, 16'hAAAA, 16'h0000, 16'h3333};
  localparam logic [15:0] VB [NV] = '{16'h0002, 16'h0034, 16'h0001, 16'h0F00, 16'h8000,
                                      16'hF0F0, 16'h0001, 16'h5555, 16'hFFFF, 16'h1111};
  localparam int          VOP[NV] = '{0, 1, 0, 2, 0, 3, 1, 2, 1, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0, ins_a_rdy = 1'b0, ins_b_rdy = 1'b0;
  logic [IW-1:0] ins_instr = '0;
  logic [DW-1:0] ins_a_data = '0, ins_b_data = '0;
  logic [TW-1:0] ins_a_tag = '0, ins_b_tag = '0;
  logic ins_ready;
  logic [TW-1:0] ins_tag;
  logic dsp_req = 1'b0, dsp_valid;
  logic [TW-1:0] dsp_tag;
  logic [IW-1:0] dsp_instr;
  logic [DW-1:0] dsp_a, dsp_b;
  logic wb_valid = 1'b0;
  logic [TW-1:0] wb_tag = '0;
  logic [DW-1:0] wb_data = '0;
  logic br_valid = 1'b0;
  logic [TW-1:0] br_tag = '0;
  logic cmt_valid;
  logic [TW-1:0] cmt_tag;
  logic [IW-1:0] cmt_instr;
  logic [DW-1:0] cmt_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  rob_core #(.DEPTH(D), .DW(DW), .IW(IW)) u_rob_core (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_instr(ins_instr),
    .ins_a_rdy(ins_a_rdy), .ins_a_data(ins_a_data), .ins_a_tag(ins_a_tag),
    .ins_b_rdy(ins_b_rdy), .ins_b_data(ins_b_data), .ins_b_tag(ins_b_tag),
    .ins_ready(ins_ready), .ins_tag(ins_tag),
    .dsp_req(dsp_req), .dsp_valid(dsp_valid), .dsp_tag(dsp_tag),
    .dsp_instr(dsp_instr), .dsp_a(dsp_a), .dsp_b(dsp_b),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .br_valid(br_valid), .br_tag(br_tag),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_instr(cmt_instr), .cmt_data(cmt_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] exec(input logic [15:0] a, input logic [15:0] b, input int op);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a ^ b;
      default: return a & b;
    endcase
  endfunction

  task automatic put(input logic [IW-1:0] ins, input logic ar, input logic [DW-1:0] ad,
                     input logic [TW-1:0] at, input logic br, input logic [DW-1:0] bd,
                     input logic [TW-1:0] bt);
    ins_valid = 1'b1; ins_instr = ins;
    ins_a_rdy = ar; ins_a_data = ad; ins_a_tag = at;
    ins_b_rdy = br; ins_b_data = bd; ins_b_tag = bt;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    check("R1 ins_ready after reset", 32'(ins_ready), 32'd1);
    check("R1 ins_tag after reset", 32'(ins_tag), 32'd0);
    check("R1 dsp_valid after reset", 32'(dsp_valid), 32'd0);
    check("R1 cmt_valid after reset", 32'(cmt_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();

    // table walk: insert, dispatch, writeback, commit (R2 R4 R5 R7 R10)
    for (int r = 0; r < NV; r++) begin
      logic [IW-1:0] iw;
      logic [DW-1:0] res;
      logic [TW-1:0] tg;
      iw  = IW'(r * 256 + VOP[r]);
      res = exec(VA[r], VB[r], VOP[r]);
      tg  = TW'(r % D);
      check("R2 R10 ins_tag wraps", 32'(ins_tag), 32'(tg));
      put(iw, 1'b1, VA[r], '0, 1'b1, VB[r], '0);
      tick();
      ins_valid = 1'b0;
      dsp_req = 1'b1;
      tick();
      dsp_req = 1'b0;
      check("R4 dsp_valid", 32'(dsp_valid), 32'd1);
      check("R4 dsp_tag", 32'(dsp_tag), 32'(tg));
      check("R4 dsp_instr", 32'(dsp_instr), 32'(iw));
      check("R4 dsp_a", 32'(dsp_a), 32'(VA[r]));
      check("R4 dsp_b", 32'(dsp_b), 32'(VB[r]));
      wb_valid = 1'b1; wb_tag = tg; wb_data = res;
      tick();
      wb_valid = 1'b0;
      tick();
      check("R7 cmt_valid", 32'(cmt_valid), 32'd1);
      check("R7 cmt_tag", 32'(cmt_tag), 32'(tg));
      check("R7 cmt_instr", 32'(cmt_instr), 32'(iw));
      check("R5 R7 cmt_data", 32'(cmt_data), 32'(res));
    end

    // dependency, forwarding, same-cycle insert + writeback
    do_reset();
    put(16'h0100, 1'b1, 16'd1, '0, 1'b1, 16'd2, '0);          // tag 0
    tick();
    put(16'h0101, 1'b0, 16'h0, 3'd0, 1'b1, 16'd7, '0);        // tag 1 waits on 0
    dsp_req = 1'b1;
    tick();
    check("R4 first dispatch tag", 32'(dsp_tag), 32'd0);
    ins_valid = 1'b0;
    tick();
    check("R4 nothing eligible", 32'(dsp_valid), 32'd0);
    dsp_req = 1'b0;
    wb_valid = 1'b1; wb_tag = 3'd0; wb_data = 16'h0055;
    put(16'h0102, 1'b0, 16'h0, 3'd0, 1'b1, 16'd9, '0);        // tag 2, same-cycle
    tick();
    ins_valid = 1'b0; wb_valid = 1'b0;
    dsp_req = 1'b1;
    tick();
    check("R7 commit tag 0", 32'(cmt_tag), 32'd0);
    check("R7 commit data 0", 32'(cmt_data), 32'h55);
    check("R5 forwarded tag", 32'(dsp_tag), 32'd1);
    check("R5 forwarded operand", 32'(dsp_a), 32'h55);
    tick();
    check("R6 same-cycle tag", 32'(dsp_tag), 32'd2);
    check("R6 same-cycle operand", 32'(dsp_a), 32'h55);
    check("R6 other operand", 32'(dsp_b), 32'd9);
    dsp_req = 1'b0;
    wb_valid = 1'b1; wb_tag = 3'd1; wb_data = 16'h0011;
    tick();
    wb_tag = 3'd2; wb_data = 16'h0022;
    tick();
    check("R7 in-order tag 1", 32'(cmt_tag), 32'd1);
    check("R7 in-order data 1", 32'(cmt_data), 32'h11);
    wb_valid = 1'b0;
    tick();
    check("R7 in-order tag 2", 32'(cmt_tag), 32'd2);
    check("R7 in-order data 2", 32'(cmt_data), 32'h22);
    tick();

    // branch kill (R8 R9): entries 3 (branch), 4, 5, plus 6 inserted in kill cycle
    put(16'h0300, 1'b1, 16'd3, '0, 1'b1, 16'd3, '0);
    tick();
    put(16'h0400, 1'b1, 16'd4, '0, 1'b1, 16'd4, '0);
    tick();
    put(16'h0500, 1'b1, 16'd5, '0, 1'b1, 16'd5, '0);
    dsp_req = 1'b1;
    tick();
    check("R4 dispatch branch tag", 32'(dsp_tag), 32'd3);
    ins_valid = 1'b0;
    tick();
    check("R4 dispatch tag 4", 32'(dsp_tag), 32'd4);
    dsp_req = 1'b0;
    br_valid = 1'b1; br_tag = 3'd3;
    put(16'h0600, 1'b1, 16'd6, '0, 1'b1, 16'd6, '0);
    tick();
    br_valid = 1'b0; ins_valid = 1'b0;
    wb_valid = 1'b1; wb_tag = 3'd4; wb_data = 16'h0099;
    tick();
    wb_tag = 3'd3; wb_data = 16'h0033;
    dsp_req = 1'b1;
    tick();
    check("R8 killed never dispatched", 32'(dsp_valid), 32'd0);
    dsp_req = 1'b0; wb_valid = 1'b0;
    tick();
    check("R7 branch commits", 32'(cmt_valid), 32'd1);
    check("R7 branch commit tag", 32'(cmt_tag), 32'd3);
    check("R7 branch commit data", 32'(cmt_data), 32'h33);
    tick();
    check("R9 killed tag 4 no commit", 32'(cmt_valid), 32'd0);
    tick();
    check("R9 killed tag 5 no commit", 32'(cmt_valid), 32'd0);
    tick();
    check("R8 R9 kill-cycle insert no commit", 32'(cmt_valid), 32'd0);
    tick();
    check("R9 no commit after drain", 32'(cmt_valid), 32'd0);
    check("R2 tail after kill", 32'(ins_tag), 32'd7);
    check("R10 empty again ready", 32'(ins_ready), 32'd1);

    // fill to full and offer one more (R3 R10)
    for (int k = 0; k < D; k++) begin
      check("R3 ready before full", 32'(ins_ready), 32'd1);
      put(IW'(k), 1'b1, DW'(k), '0, 1'b1, 16'd1, '0);
      tick();
    end
    ins_valid = 1'b0;
    check("R3 R10 full deasserts ready", 32'(ins_ready), 32'd0);
    put(16'h0BAD, 1'b1, 16'hDEAD, '0, 1'b1, 16'hDEAD, '0);
    tick();
    ins_valid = 1'b0;
    check("R3 ignored insert keeps tag", 32'(ins_tag), 32'd7);
    check("R3 still full", 32'(ins_ready), 32'd0);
    for (int k = 0; k < D; k++) begin
      dsp_req = 1'b1;
      tick();
      check("R4 oldest-first tag", 32'(dsp_tag), 32'((7 + k) % D));
      check("R4 oldest-first operand", 32'(dsp_a), 32'(k));
    end
    dsp_req = 1'b0;
    for (int k = 0; k < D; k++) begin
      wb_valid = 1'b1; wb_tag = TW'((7 + k) % D); wb_data = DW'(k + 100);
      tick();
      if (k > 0) begin
        check("R7 full drain tag", 32'(cmt_tag), 32'((7 + k - 1) % D));
        check("R7 full drain data", 32'(cmt_data), 32'(k - 1 + 100));
      end
    end
    wb_valid = 1'b0;
    tick();
    check("R7 last drain tag", 32'(cmt_tag), 32'((7 + D - 1) % D));
    check("R7 last drain data", 32'(cmt_data), 32'(D - 1 + 100));
    tick();
    check("R3 no extra commit", 32'(cmt_valid), 32'd0);
    dsp_req = 1'b1;
    tick();
    dsp_req = 1'b0;
    check("R3 rejected insert absent", 32'(dsp_valid), 32'd0);
    check("R10 empty ready", 32'(ins_ready), 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule